// File: doc/BRIEF.md
# Receiver Front-End Power Mode Controller

This block keeps track of the power state of a low-frequency receiver front end and drives the enables that gate its receive circuitry. It has three states. In Sleep, every receive enable is off, including the RF limiter. In Standby the receiver is powered and waiting for a signal. In Operating a low-frequency signal is present and the receive path is switching with data. The inputs are a command strobe with an opcode taken from an already decoded serial command, a signal-present flag from the receive path, and a synchronous active-low power-on reset.

A Sleep opcode from any awake state enters Sleep. Any other valid command wakes the block, and so does a reset. While awake, the state follows the signal-present flag, which the state register samples on each clock edge. The retention enable and the serial-port enable stay high in every state, so configuration contents and command reception survive Sleep. A one-hot copy of the state is brought out for observation.

Top module: `pmc_power_ctrl`

## Requirements
- R1: A clock edge with `rst_n` low puts the block in Standby. After that edge `state_oh` is 3'b010 and every `rx_en` bit is 1, whatever the other inputs are.
- R2: A clock edge with `cmd_vld` high and `cmd_op` equal to `SLEEP_OP` (default 4'hA) puts the block in Sleep from any state. This command takes priority over `sig_present`.
- R3: While in Sleep, every bit of `rx_en`, including the limiter enable at bit 0, is 0.
- R4: `retain_en` and `spi_en` are 1 in every state, including Sleep and the cycles after reset.
- R5: In Sleep, an edge with `cmd_vld` high and `cmd_op` different from `SLEEP_OP` wakes the block. It enters Operating if `sig_present` is 1 at that edge and Standby otherwise.
- R6: In Sleep, an edge with no valid command, or with a repeated Sleep command, leaves the block in Sleep, whatever `sig_present` is.
- R7: While awake and without a Sleep command, the state after an edge is Operating if `sig_present` was 1 at that edge and Standby if it was 0. A non-Sleep command changes nothing here.
- R8: `state_oh` has exactly one bit set. Bit 0 means Sleep, bit 1 means Standby and bit 2 means Operating.
- R9: In Standby and in Operating, every bit of `rx_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| cmd_vld | input | 1 | Strobe for a decoded serial command, valid for one cycle |
| cmd_op | input | OP_W | Opcode of the command |
| sig_present | input | 1 | Low-frequency signal detected on the antenna inputs |
| rx_en | output | N_RX | Receive-circuit enables; bit 0 gates the RF limiter |
| retain_en | output | 1 | Register-retention enable, always on |
| spi_en | output | 1 | Serial-port enable, always on |
| state_oh | output | 3 | One-hot state: bit 0 Sleep, bit 1 Standby, bit 2 Operating |

## Verification
Two functions can act in the same cycle. A Sleep command can arrive on the edge where `sig_present` changes, and a wake command can arrive while `sig_present` is high. The random stimulus draws `cmd_vld`, the opcode and `sig_present` independently on every cycle, so these overlaps occur often. Directed sequences also set them up on purpose, together with a reset asserted during Sleep with a command pending. After each edge, the bench's reference function computes the expected state from the priority order: reset first, then the Sleep command, then waking, then tracking the signal. The outputs are compared with that result.

// File: rtl/pmc_pkg.sv
// Package: shared state encoding for the power mode controller.
// Assumes: three power states; one-hot bit order Sleep, Standby, Operating.
package pmc_pkg;
    typedef enum logic [1:0] {
        PM_SLEEP   = 2'd0,
        PM_STANDBY = 2'd1,
        PM_OPER    = 2'd2
    } pm_state_t;

    localparam int unsigned PM_NSTATES = 3;
endpackage

// File: rtl/pmc_next_state.sv
// Module: next-state selection for the power mode controller.
// Assumes: cmd_op is meaningful only while cmd_vld is high; reset is
// handled by the state register, not here.
module pmc_next_state
    import pmc_pkg::*;
#(
    parameter int unsigned       OP_W     = 4,
    parameter logic [OP_W-1:0]   SLEEP_OP = 4'hA
) (
    input  pm_state_t        cur,
    input  logic             cmd_vld,
    input  logic [OP_W-1:0]  cmd_op,
    input  logic             sig_present,
    output pm_state_t        nxt
);
    logic sleep_cmd;
    logic wake_cmd;

    // Split a valid command into sleep and wake classes.
    always_comb begin
        sleep_cmd = cmd_vld && (cmd_op == SLEEP_OP);
        wake_cmd  = cmd_vld && (cmd_op != SLEEP_OP);
    end

    // Priority: sleep command, then held sleep, then signal tracking.
    always_comb begin
        if (sleep_cmd) begin
            nxt = PM_SLEEP;
        end else if ((cur == PM_SLEEP) && !wake_cmd) begin
            nxt = PM_SLEEP;
        end else if (sig_present) begin
            nxt = PM_OPER;
        end else begin
            nxt = PM_STANDBY;
        end
    end
endmodule

// File: rtl/pmc_enable_decode.sv
// Module: turns the power state into enables and a one-hot state view.
// Assumes: state holds one of the three legal encodings.
module pmc_enable_decode
    import pmc_pkg::*;
#(
    parameter int unsigned N_RX = 2
) (
    input  pm_state_t              state,
    output logic [N_RX-1:0]        rx_en,
    output logic                   retain_en,
    output logic                   spi_en,
    output logic [PM_NSTATES-1:0]  state_oh
);
    logic awake;

    // One-hot state view and awake flag.
    always_comb begin
        state_oh    = '0;
        state_oh[0] = (state == PM_SLEEP);
        state_oh[1] = (state == PM_STANDBY);
        state_oh[2] = (state == PM_OPER);
        awake       = (state != PM_SLEEP);
    end

    // One enable per receive circuit, all gated by the awake flag.
    for (genvar g = 0; g < N_RX; g++) begin : g_rx
        assign rx_en[g] = awake;
    end

    // Retention and serial port stay on in every state.
    always_comb begin
        retain_en = 1'b1;
        spi_en    = 1'b1;
    end
endmodule

// File: rtl/pmc_power_ctrl.sv
// Module: top of the receiver front-end power mode controller.
// Holds the state register and wires next-state and decode logic.
// Assumes: rst_n is synchronous and active low; sig_present is already
// synchronous to clk; the state register is its only registration.
module pmc_power_ctrl
    import pmc_pkg::*;
#(
    parameter int unsigned      OP_W     = 4,
    parameter logic [OP_W-1:0]  SLEEP_OP = 4'hA,
    parameter int unsigned      N_RX     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_vld,
    input  logic [OP_W-1:0]  cmd_op,
    input  logic             sig_present,
    output logic [N_RX-1:0]  rx_en,
    output logic             retain_en,
    output logic             spi_en,
    output logic [2:0]       state_oh
);
    pm_state_t state_q;
    pm_state_t state_d;

    pmc_next_state #(.OP_W(OP_W), .SLEEP_OP(SLEEP_OP)) u_next (
        .cur         (state_q),
        .cmd_vld     (cmd_vld),
        .cmd_op      (cmd_op),
        .sig_present (sig_present),
        .nxt         (state_d)
    );

    // State register; reset lands in Standby.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PM_STANDBY;
        end else begin
            state_q <= state_d;
        end
    end

    pmc_enable_decode #(.N_RX(N_RX)) u_dec (
        .state     (state_q),
        .rx_en     (rx_en),
        .retain_en (retain_en),
        .spi_en    (spi_en),
        .state_oh  (state_oh)
    );

    // Assertions guarding the state register and its decode.
    assert_reset_standby_R1: assert property (@(posedge clk)
        !rst_n |=> (state_oh == 3'b010) && (&rx_en));

    assert_sleep_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd_op == SLEEP_OP) |=> state_oh[0]);

    assert_sleep_gates_rx_R3: assert property (@(posedge clk) disable iff (!rst_n)
        state_oh[0] |-> (rx_en == '0));

    assert_always_on_R4: assert property (@(posedge clk)
        retain_en && spi_en);

    assert_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_oh[0] && cmd_vld && cmd_op != SLEEP_OP)
        |=> (state_oh[2] == $past(sig_present)) && !state_oh[0]);

    assert_sleep_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_oh[0] && !(cmd_vld && cmd_op != SLEEP_OP)) |=> state_oh[0]);

    assert_track_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!state_oh[0] && !(cmd_vld && cmd_op == SLEEP_OP))
        |=> (state_oh[2] == $past(sig_present)) && !state_oh[0]);

    assert_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state_oh) == 1);

    assert_awake_rx_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !state_oh[0] |-> (&rx_en));
endmodule

// File: tb/sim_pmc_power_ctrl.sv
module sim_pmc_power_ctrl;
    localparam int unsigned     OP_W     = 4;
    localparam logic [OP_W-1:0] SLEEP_OP = 4'hA;
    localparam int unsigned     N_RX     = 2;
    localparam logic [2:0]      OH_SLP   = 3'b001;
    localparam logic [2:0]      OH_STB   = 3'b010;
    localparam logic [2:0]      OH_OPR   = 3'b100;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            cmd_vld;
    logic [OP_W-1:0] cmd_op;
    logic            sig_present;
    logic [N_RX-1:0] rx_en;
    logic            retain_en;
    logic            spi_en;
    logic [2:0]      state_oh;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [2:0] exp_oh;

    always #5 clk = ~clk;

    pmc_power_ctrl #(.OP_W(OP_W), .SLEEP_OP(SLEEP_OP), .N_RX(N_RX)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
        .sig_present(sig_present), .rx_en(rx_en), .retain_en(retain_en),
        .spi_en(spi_en), .state_oh(state_oh)
    );

    // Reference next state from the requirement priority order.
    function automatic logic [2:0] ref_next(logic [2:0] cur, logic r, logic v,
                                            logic [OP_W-1:0] op, logic s);
        if (!r) return OH_STB;                         // R1
        if (v && op == SLEEP_OP) return OH_SLP;        // R2
        if (cur == OH_SLP && !v) return OH_SLP;        // R6
        return s ? OH_OPR : OH_STB;                    // R5, R7
    endfunction

    function automatic string ref_tag(logic [2:0] cur, logic r, logic v,
                                      logic [OP_W-1:0] op);
        if (!r) return "R1";
        if (v && op == SLEEP_OP) return "R2";
        if (cur == OH_SLP) return v ? "R5" : "R6";
        return "R7";
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, compare after the edge.
    task automatic step(logic r, logic v, logic [OP_W-1:0] op, logic s);
        string tag;
        @(negedge clk);
        rst_n = r; cmd_vld = v; cmd_op = op; sig_present = s;
        tag = ref_tag(exp_oh, r, v, op);
        exp_oh = ref_next(exp_oh, r, v, op, s);
        @(posedge clk);
        #2;
        chk(tag, {29'd0, state_oh}, {29'd0, exp_oh});
        chk("R8", $countones(state_oh), 1);
        chk("R4", {30'd0, retain_en, spi_en}, 32'd3);
        if (exp_oh == OH_SLP) chk("R3", {{(32-N_RX){1'b0}}, rx_en}, 32'd0);
        else chk("R9", {{(32-N_RX){1'b0}}, rx_en}, {{(32-N_RX){1'b0}}, {N_RX{1'b1}}});
    endtask

    initial begin
        logic [OP_W-1:0] wake_op;
        void'($urandom(32'd1234));
        exp_oh = OH_STB;
        rst_n = 1'b0; cmd_vld = 1'b0; cmd_op = '0; sig_present = 1'b0;
        // Reset state, with a sleep command pending (R1 wins).
        step(1'b0, 1'b1, SLEEP_OP, 1'b1);
        step(1'b0, 1'b0, 4'h0, 1'b0);
        // Tracking in both directions (R7).
        step(1'b1, 1'b0, 4'h0, 1'b1);
        step(1'b1, 1'b1, 4'h3, 1'b0);
        // Sleep command on the edge where the signal rises (R2).
        step(1'b1, 1'b1, SLEEP_OP, 1'b1);
        // Repeated sleep and signal changes stay asleep (R6).
        step(1'b1, 1'b1, SLEEP_OP, 1'b0);
        step(1'b1, 1'b0, 4'h0, 1'b1);
        // Wake while signal present goes to Operating (R5).
        step(1'b1, 1'b1, 4'h5, 1'b1);
        step(1'b1, 1'b1, SLEEP_OP, 1'b0);
        // Wake with no signal goes to Standby (R5).
        step(1'b1, 1'b1, 4'hF, 1'b0);
        step(1'b1, 1'b1, SLEEP_OP, 1'b0);
        // Reset while asleep with a wake command pending (R1).
        step(1'b0, 1'b1, 4'h1, 1'b1);
        step(1'b1, 1'b0, 4'h0, 1'b1);
        // Constrained random mix.
        for (int i = 0; i < 2000; i++) begin
            logic r, v, s;
            logic [OP_W-1:0] op;
            r  = ($urandom_range(0, 99) >= 2);
            v  = ($urandom_range(0, 99) < 30);
            s  = $urandom_range(0, 1) == 1;
            wake_op = OP_W'($urandom_range(0, (1 << OP_W) - 1));
            op = ($urandom_range(0, 99) < 40) ? SLEEP_OP : wake_op;
            step(r, v, op, s);
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule